// File: doc/BRIEF.md
# Transactional Region Nesting Controller

This block follows a processor's entry into and exit from hardware transactional regions. Each cycle it takes at most one event: a begin, an end, an abort, or an entry into or exit from a suspended-tracking section. Alongside a begin it receives the current instruction pointer, a relative offset, an operand-size flag, the execution mode, a code-segment limit, the feature word and a lock-prefix flag. It keeps a nesting depth, an active flag, a suspend flag and a latched fallback target.

The outermost begin computes the fallback target from the pointer and the offset, and checks that target against the rules of the current mode. If the target is legal, the block opens the region and pulses a checkpoint strobe. Inner begins only deepen the nesting. A begin that cannot nest, because the depth is at its maximum or tracking is suspended, is turned into an abort.

Abort processing clears the state, pulses restore and discard strobes, writes a status word and issues a redirect to the latched target. Register checkpointing and the discarding of memory updates belong to other logic and appear here only as strobes. Every output is a register, so it changes one clock after the event that drives it.

Top module: `txn_nest_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, nest_depth is 0, and txn_active, susp_active and every strobe and fault output are 0.
- R2: A legal begin increments nest_depth when nest_depth is below MAX_NEST and susp_active is 0. The outermost begin (depth 0 to 1) also sets txn_active and pulses ckpt_start for one cycle. An inner begin does not pulse ckpt_start.
- R3: The fallback target is latched only on the outermost begin. Inner begins leave it unchanged, and a later abort redirects to the target of the outermost begin.
- R4: In 64-bit mode (exec_mode 3) the target is ip_cur plus the offset sign-extended to 64 bits. If target bits 63..47 are not all equal, fault_gp pulses.
- R5: With opsz16=1 only rel_off[15:0] is used, sign-extended. The sum is never truncated to 16 bits.
- R6: In 32-bit protected mode (exec_mode 2) the target is ip_cur[31:0] plus the offset, taken modulo 2^32 and zero-extended. If that target is greater than cs_limit, fault_gp pulses.
- R7: In real mode (exec_mode 0) and virtual-8086 mode (exec_mode 1) the target is computed as in R6. If the target is above 0xFFFF, fault_gp pulses.
- R8: A begin at nest_depth = MAX_NEST, or while susp_active = 1, performs abort processing. acc_status bit 1 is set for the depth case and bit 2 for the suspend case.
- R9: Abort processing, whether from abort_valid while txn_active or from R8, has the following effects one cycle later:
  - nest_depth, txn_active and susp_active are 0;
  - restore_stb, discard_stb and redirect_valid each pulse for one cycle;
  - redirect_ip holds the latched target;
  - acc_status is written, with bit 0 set for an explicit abort.
- R10: A begin with feat_word bit 11 = 0, or with lock_pfx = 1, pulses fault_ud.
- R11: A begin that raises fault_ud or fault_gp leaves nest_depth, txn_active, susp_active and the latched target unchanged. fault_ud takes priority over every other outcome of a begin.
- R12: An end while nest_depth > 0 decrements nest_depth. The end that reaches 0 clears txn_active and susp_active and pulses commit_stb. An end at depth 0, or an abort while txn_active = 0, changes no output.
- R13: susp_enter sets susp_active only while txn_active = 1. susp_exit clears susp_active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| begin_valid | input | 1 | Begin event |
| end_valid | input | 1 | End event |
| abort_valid | input | 1 | Explicit abort event |
| susp_enter | input | 1 | Enter suspended tracking |
| susp_exit | input | 1 | Leave suspended tracking |
| ip_cur | input | 64 | Pointer of the following instruction |
| rel_off | input | 32 | Relative offset |
| opsz16 | input | 1 | 1 selects the 16-bit offset |
| exec_mode | input | 2 | 0 real, 1 virtual-8086, 2 protected 32-bit, 3 64-bit |
| cs_limit | input | 32 | Code-segment limit |
| feat_word | input | 32 | Feature word; bit 11 enables the block |
| lock_pfx | input | 1 | Lock prefix present |
| nest_depth | output | 3 | Nesting depth |
| txn_active | output | 1 | Region open |
| susp_active | output | 1 | Tracking suspended |
| ckpt_start | output | 1 | Start checkpoint strobe |
| commit_stb | output | 1 | Outermost end strobe |
| restore_stb | output | 1 | Restore registers strobe |
| discard_stb | output | 1 | Discard memory updates strobe |
| redirect_valid | output | 1 | Redirect strobe |
| redirect_ip | output | 64 | Redirect target |
| acc_status | output | 32 | Abort status word |
| fault_ud | output | 1 | Undefined-opcode fault strobe |
| fault_gp | output | 1 | General-protection fault strobe |

## Verification
A wrong latched target stays hidden until the next abort, so each scenario ends with an abort and compares redirect_ip one cycle later. A stray inner-begin latch shows up as a redirect to the inner pointer. A depth counter that is off by one appears as an abort one begin too early or too late in the overflow sequence, or as a missing commit_stb. A fault that wrongly updates state shows up as a changed nest_depth in the cycle after the fault.

// File: rtl/txn_pkg.sv
package txn_pkg;
  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_V86  = 2'd1,
    MODE_P32  = 2'd2,
    MODE_L64  = 2'd3
  } exec_mode_e;

  localparam int STAT_W        = 32;
  localparam int STAT_EXPLICIT = 0;
  localparam int STAT_NESTMAX  = 1;
  localparam int STAT_SUSPEND  = 2;
endpackage

// File: rtl/txn_target_calc.sv
module txn_target_calc
  import txn_pkg::*;
#(
  parameter int IP_W    = 64,
  parameter int OFF_W   = 32,
  parameter int VA_BITS = 48
) (
  input  logic [IP_W-1:0]  ip_cur,
  input  logic [OFF_W-1:0] rel_off,
  input  logic             opsz16,
  input  logic [1:0]       exec_mode,
  input  logic [31:0]      cs_limit,
  output logic [IP_W-1:0]  fb_addr,
  output logic             gp_bad
);
  localparam int HI_W = IP_W - VA_BITS + 1;

  logic [IP_W-1:0] off_wide;
  logic [IP_W-1:0] sum_wide;
  logic [31:0]     off_narrow;
  logic [31:0]     sum_narrow;
  logic [HI_W-1:0] hi_bits;
  logic            canon_ok;

  always_comb begin
    if (opsz16) begin
      off_wide   = {{(IP_W-16){rel_off[15]}}, rel_off[15:0]};
      off_narrow = {{16{rel_off[15]}}, rel_off[15:0]};
    end else begin
      off_wide   = {{(IP_W-OFF_W){rel_off[OFF_W-1]}}, rel_off};
      off_narrow = rel_off[31:0];
    end
    sum_wide   = ip_cur + off_wide;
    sum_narrow = ip_cur[31:0] + off_narrow;
    hi_bits    = sum_wide[IP_W-1:VA_BITS-1];
    canon_ok   = (&hi_bits) | ~(|hi_bits);
  end

  always_comb begin
    case (exec_mode_e'(exec_mode))
      MODE_L64: begin
        fb_addr = sum_wide;
        gp_bad  = ~canon_ok;
      end
      MODE_P32: begin
        fb_addr = {{(IP_W-32){1'b0}}, sum_narrow};
        gp_bad  = (sum_narrow > cs_limit);
      end
      default: begin
        fb_addr = {{(IP_W-32){1'b0}}, sum_narrow};
        gp_bad  = |sum_narrow[31:16];
      end
    endcase
  end
endmodule

// File: rtl/txn_fault_dec.sv
module txn_fault_dec #(
  parameter int FEAT_W   = 32,
  parameter int FEAT_BIT = 11
) (
  input  logic [FEAT_W-1:0] feat_word,
  input  logic              lock_pfx,
  output logic              ud_bad
);
  logic feat_unused;
  assign feat_unused = ^feat_word;
  assign ud_bad = ~feat_word[FEAT_BIT] | lock_pfx;
endmodule

// File: rtl/txn_nest_core.sv
module txn_nest_core
  import txn_pkg::*;
#(
  parameter int IP_W     = 64,
  parameter int MAX_NEST = 7,
  parameter int CW       = $clog2(MAX_NEST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              begin_valid,
  input  logic              end_valid,
  input  logic              abort_valid,
  input  logic              susp_enter,
  input  logic              susp_exit,
  input  logic [IP_W-1:0]   fb_addr,
  input  logic              gp_bad,
  input  logic              ud_bad,
  output logic [CW-1:0]     nest_depth,
  output logic              txn_active,
  output logic              susp_active,
  output logic              ckpt_start,
  output logic              commit_stb,
  output logic              restore_stb,
  output logic              discard_stb,
  output logic              redirect_valid,
  output logic [IP_W-1:0]   redirect_ip,
  output logic [STAT_W-1:0] acc_status,
  output logic              fault_ud,
  output logic              fault_gp
);
  localparam logic [CW-1:0] DEPTH_MAX = CW'(MAX_NEST);
  localparam logic [CW-1:0] DEPTH_ONE = CW'(1);

  logic [CW-1:0]     depth_q, depth_d;
  logic              act_q, act_d;
  logic              susp_q, susp_d;
  logic [IP_W-1:0]   fb_q, fb_d;
  logic              ckpt_d, commit_d, abort_d, ud_d, gp_d;
  logic [STAT_W-1:0] stat_q, stat_d;
  logic              stat_en;
  logic              ckpt_q, commit_q, abort_q, ud_q, gp_q;
  logic [IP_W-1:0]   rdr_q;

  always_comb begin
    depth_d  = depth_q;
    act_d    = act_q;
    susp_d   = susp_q;
    fb_d     = fb_q;
    ckpt_d   = 1'b0;
    commit_d = 1'b0;
    abort_d  = 1'b0;
    ud_d     = 1'b0;
    gp_d     = 1'b0;
    stat_d   = '0;
    if (abort_valid && act_q) begin
      abort_d               = 1'b1;
      stat_d[STAT_EXPLICIT] = 1'b1;
    end else if (begin_valid) begin
      if (ud_bad) begin
        ud_d = 1'b1;
      end else if ((depth_q < DEPTH_MAX) && !susp_q) begin
        if (depth_q == '0) begin
          if (gp_bad) begin
            gp_d = 1'b1;
          end else begin
            depth_d = DEPTH_ONE;
            act_d   = 1'b1;
            fb_d    = fb_addr;
            ckpt_d  = 1'b1;
          end
        end else begin
          depth_d = depth_q + DEPTH_ONE;
        end
      end else begin
        abort_d              = 1'b1;
        stat_d[STAT_NESTMAX] = (depth_q == DEPTH_MAX);
        stat_d[STAT_SUSPEND] = susp_q;
      end
    end else if (end_valid && (depth_q != '0)) begin
      depth_d = depth_q - DEPTH_ONE;
      if (depth_q == DEPTH_ONE) begin
        act_d    = 1'b0;
        susp_d   = 1'b0;
        commit_d = 1'b1;
      end
    end else if (susp_enter && act_q) begin
      susp_d = 1'b1;
    end else if (susp_exit) begin
      susp_d = 1'b0;
    end
    if (abort_d) begin
      depth_d = '0;
      act_d   = 1'b0;
      susp_d  = 1'b0;
    end
    stat_en = abort_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q  <= '0;
      act_q    <= 1'b0;
      susp_q   <= 1'b0;
      fb_q     <= '0;
      ckpt_q   <= 1'b0;
      commit_q <= 1'b0;
      abort_q  <= 1'b0;
      ud_q     <= 1'b0;
      gp_q     <= 1'b0;
      stat_q   <= '0;
      rdr_q    <= '0;
    end else begin
      depth_q  <= depth_d;
      act_q    <= act_d;
      susp_q   <= susp_d;
      fb_q     <= fb_d;
      ckpt_q   <= ckpt_d;
      commit_q <= commit_d;
      abort_q  <= abort_d;
      ud_q     <= ud_d;
      gp_q     <= gp_d;
      if (stat_en) begin
        stat_q <= stat_d;
        rdr_q  <= fb_q;
      end
    end
  end

  assign nest_depth     = depth_q;
  assign txn_active     = act_q;
  assign susp_active    = susp_q;
  assign ckpt_start     = ckpt_q;
  assign commit_stb     = commit_q;
  assign restore_stb    = abort_q;
  assign discard_stb    = abort_q;
  assign redirect_valid = abort_q;
  assign redirect_ip    = rdr_q;
  assign acc_status     = stat_q;
  assign fault_ud       = ud_q;
  assign fault_gp       = gp_q;

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= DEPTH_MAX); // R2
  AST_ACTIVE_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    act_q == (depth_q != '0)); // R12
  AST_SUSP_NEEDS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    susp_q |-> act_q); // R13
  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ud_q || gp_q) |-> ($stable(depth_q) && $stable(fb_q))); // R11
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> (depth_q == '0 && !act_q && !susp_q)); // R9
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ckpt_q, abort_q, ud_q, gp_q, commit_q})); // R10
  AST_INNER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !ckpt_q) |-> $stable(fb_q)); // R3
endmodule

// File: rtl/txn_nest_ctrl.sv
module txn_nest_ctrl
  import txn_pkg::*;
#(
  parameter int IP_W     = 64,
  parameter int OFF_W    = 32,
  parameter int VA_BITS  = 48,
  parameter int MAX_NEST = 7,
  parameter int FEAT_W   = 32,
  parameter int FEAT_BIT = 11,
  parameter int CW       = $clog2(MAX_NEST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              begin_valid,
  input  logic              end_valid,
  input  logic              abort_valid,
  input  logic              susp_enter,
  input  logic              susp_exit,
  input  logic [IP_W-1:0]   ip_cur,
  input  logic [OFF_W-1:0]  rel_off,
  input  logic              opsz16,
  input  logic [1:0]        exec_mode,
  input  logic [31:0]       cs_limit,
  input  logic [FEAT_W-1:0] feat_word,
  input  logic              lock_pfx,
  output logic [CW-1:0]     nest_depth,
  output logic              txn_active,
  output logic              susp_active,
  output logic              ckpt_start,
  output logic              commit_stb,
  output logic              restore_stb,
  output logic              discard_stb,
  output logic              redirect_valid,
  output logic [IP_W-1:0]   redirect_ip,
  output logic [STAT_W-1:0] acc_status,
  output logic              fault_ud,
  output logic              fault_gp
);
  logic [IP_W-1:0] fb_addr;
  logic            gp_bad;
  logic            ud_bad;

  txn_target_calc #(.IP_W(IP_W), .OFF_W(OFF_W), .VA_BITS(VA_BITS)) u_calc (
    .ip_cur(ip_cur), .rel_off(rel_off), .opsz16(opsz16),
    .exec_mode(exec_mode), .cs_limit(cs_limit),
    .fb_addr(fb_addr), .gp_bad(gp_bad)
  );

  txn_fault_dec #(.FEAT_W(FEAT_W), .FEAT_BIT(FEAT_BIT)) u_dec (
    .feat_word(feat_word), .lock_pfx(lock_pfx), .ud_bad(ud_bad)
  );

  txn_nest_core #(.IP_W(IP_W), .MAX_NEST(MAX_NEST), .CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n),
    .begin_valid(begin_valid), .end_valid(end_valid),
    .abort_valid(abort_valid), .susp_enter(susp_enter), .susp_exit(susp_exit),
    .fb_addr(fb_addr), .gp_bad(gp_bad), .ud_bad(ud_bad),
    .nest_depth(nest_depth), .txn_active(txn_active), .susp_active(susp_active),
    .ckpt_start(ckpt_start), .commit_stb(commit_stb),
    .restore_stb(restore_stb), .discard_stb(discard_stb),
    .redirect_valid(redirect_valid), .redirect_ip(redirect_ip),
    .acc_status(acc_status), .fault_ud(fault_ud), .fault_gp(fault_gp)
  );
endmodule

// File: tb/txn_nest_ctrl_bench.sv
module txn_nest_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic begin_valid, end_valid, abort_valid, susp_enter, susp_exit;
  logic [63:0] ip_cur;
  logic [31:0] rel_off;
  logic opsz16;
  logic [1:0] exec_mode;
  logic [31:0] cs_limit, feat_word;
  logic lock_pfx;
  logic [2:0] nest_depth;
  logic txn_active, susp_active, ckpt_start, commit_stb, restore_stb, discard_stb;
  logic redirect_valid, fault_ud, fault_gp;
  logic [63:0] redirect_ip;
  logic [31:0] acc_status;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  txn_nest_ctrl u_txn_nest_ctrl (
    .clk(clk), .rst_n(rst_n), .begin_valid(begin_valid), .end_valid(end_valid),
    .abort_valid(abort_valid), .susp_enter(susp_enter), .susp_exit(susp_exit),
    .ip_cur(ip_cur), .rel_off(rel_off), .opsz16(opsz16), .exec_mode(exec_mode),
    .cs_limit(cs_limit), .feat_word(feat_word), .lock_pfx(lock_pfx),
    .nest_depth(nest_depth), .txn_active(txn_active), .susp_active(susp_active),
    .ckpt_start(ckpt_start), .commit_stb(commit_stb), .restore_stb(restore_stb),
    .discard_stb(discard_stb), .redirect_valid(redirect_valid),
    .redirect_ip(redirect_ip), .acc_status(acc_status),
    .fault_ud(fault_ud), .fault_gp(fault_gp)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    begin_valid = 0; end_valid = 0; abort_valid = 0; susp_enter = 0; susp_exit = 0;
  endtask

  // Pulse one event for one cycle; outputs are sampled at the next falling edge.
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic do_begin(logic [1:0] m, logic [63:0] ip, logic [31:0] rel, logic o16);
    exec_mode = m; ip_cur = ip; rel_off = rel; opsz16 = o16; begin_valid = 1;
    step();
  endtask

  task automatic do_abort();
    abort_valid = 1; step();
  endtask

  task automatic do_end();
    end_valid = 1; step();
  endtask

  task automatic t_reset();
    chk("R1 depth", nest_depth, 0);
    chk("R1 flags", {txn_active, susp_active, ckpt_start, restore_stb, fault_ud, fault_gp}, 0);
  endtask

  task automatic t_long_nest();
    do_begin(2'd3, 64'h0000_0000_0040_0000, 32'hFFFF_FF00, 0);
    chk("R2 ckpt", ckpt_start, 1);
    chk("R2 depth", nest_depth, 1);
    chk("R2 active", txn_active, 1);
    do_begin(2'd3, 64'h0000_0000_0090_0000, 32'h0000_0100, 0);
    chk("R2 inner depth", nest_depth, 2);
    chk("R2 inner no ckpt", ckpt_start, 0);
    do_abort();
    chk("R9 strobes", {restore_stb, discard_stb, redirect_valid}, 3'b111);
    chk("R3 redirect", redirect_ip, 64'h0000_0000_003F_FF00);
    chk("R9 status", acc_status, 32'h1);
    chk("R9 cleared", {nest_depth, txn_active, susp_active}, 0);
    step();
    chk("R9 one pulse", redirect_valid, 0);
  endtask

  task automatic t_overflow();
    do_begin(2'd3, 64'h1000, 32'h40, 0);
    for (int i = 0; i < 6; i++) do_begin(2'd3, 64'h5000, 32'h0, 0);
    chk("R2 max depth", nest_depth, 7);
    do_begin(2'd3, 64'h5000, 32'h0, 0);
    chk("R8 overflow abort", redirect_valid, 1);
    chk("R8 overflow status", acc_status, 32'h2);
    chk("R8 overflow target", redirect_ip, 64'h1040);
    chk("R8 depth cleared", nest_depth, 0);
  endtask

  task automatic t_suspend();
    susp_enter = 1; step();
    chk("R13 enter while idle ignored", susp_active, 0);
    do_begin(2'd3, 64'h2000, 32'h10, 0);
    susp_enter = 1; step();
    chk("R13 suspend set", susp_active, 1);
    susp_exit = 1; step();
    chk("R13 suspend cleared", susp_active, 0);
    susp_enter = 1; step();
    do_begin(2'd3, 64'h7000, 32'h0, 0);
    chk("R8 suspend status", acc_status, 32'h4);
    chk("R8 suspend redirect", redirect_ip, 64'h2010);
    chk("R9 suspend cleared", {susp_active, txn_active}, 0);
  endtask

  task automatic t_ud();
    feat_word = 32'h0;
    do_begin(2'd3, 64'h3000, 32'h0, 0);
    chk("R10 feature clear", fault_ud, 1);
    chk("R11 ud depth held", nest_depth, 0);
    feat_word = 32'h800;
    do_begin(2'd3, 64'h3000, 32'h20, 0);
    lock_pfx = 1;
    do_begin(2'd3, 64'h8000, 32'h0, 0);
    lock_pfx = 0;
    chk("R10 lock", fault_ud, 1);
    chk("R11 lock depth held", nest_depth, 1);
    do_end();
    chk("R12 commit", commit_stb, 1);
    chk("R12 end depth", {nest_depth, txn_active}, 0);
  endtask

  task automatic t_gp_long();
    do_begin(2'd3, 64'h0000_7FFF_FFFF_FF00, 32'h200, 0);
    chk("R4 noncanonical", fault_gp, 1);
    chk("R11 gp state held", {nest_depth, txn_active}, 0);
    do_begin(2'd3, 64'hFFFF_8000_0000_0100, 32'hFFFF_FF00, 0);
    chk("R4 canonical high", {fault_gp, ckpt_start}, 2'b01);
    do_abort();
    chk("R4 high target", redirect_ip, 64'hFFFF_8000_0000_0000);
  endtask

  task automatic t_op16_long();
    do_begin(2'd3, 64'h1_0000, 32'h1234_8000, 1);
    do_abort();
    chk("R5 long sext16", redirect_ip, 64'h8000);
  endtask

  task automatic t_p32();
    cs_limit = 32'hFFFF;
    do_begin(2'd2, 64'h2000, 32'h0000_FFF0, 1);
    do_abort();
    chk("R6 p32 rel16", redirect_ip, 64'h1FF0);
    cs_limit = 32'h1FEF;
    do_begin(2'd2, 64'h2000, 32'h0000_FFF0, 1);
    chk("R6 above limit", fault_gp, 1);
    cs_limit = 32'hFFFF_FFFF;
    do_begin(2'd2, 64'hABCD_0000_0001_0000, 32'h0010_0000, 0);
    do_abort();
    chk("R6 p32 rel32", redirect_ip, 64'h0011_0000);
  endtask

  task automatic t_real();
    do_begin(2'd0, 64'hFFF0, 32'h20, 1);
    chk("R7 real no truncation", fault_gp, 1);
    do_begin(2'd1, 64'h1000, 32'hFFF0, 1);
    chk("R7 v86 ok", fault_gp, 0);
    do_abort();
    chk("R7 v86 target", redirect_ip, 64'h0FF0);
  endtask

  task automatic t_ignored();
    do_end();
    chk("R12 end idle", {nest_depth, commit_stb}, 0);
    do_abort();
    chk("R12 abort idle", {redirect_valid, restore_stb}, 0);
    chk("R12 abort idle target", redirect_ip, 64'h0FF0);
  endtask

  initial begin
    idle();
    rst_n = 0; ip_cur = 0; rel_off = 0; opsz16 = 0; exec_mode = 2'd3;
    cs_limit = 32'hFFFF_FFFF; feat_word = 32'h800; lock_pfx = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_long_nest();
    t_overflow();
    t_suspend();
    t_ud();
    t_gp_long();
    t_op16_long();
    t_p32();
    t_real();
    t_ignored();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(negedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule